// File: doc/BRIEF.md
# UV-Erasable Byte Memory Control with Identifier Readout

This block holds the control logic of a byte-wide, ultraviolet-erasable read-only memory. It also holds a small register array that stands in for the cell matrix. It decodes four indications into one operating mode: the active-low chip select, the active-low output gate, a flag that reports the programming supply, and a flag that reports a high voltage on address bit 9. The analog voltage detectors are modelled as these digital flags. Ultraviolet erasure is modelled as a single-cycle erase input.

The data bus is split into an output byte and a drive-enable, which together form the tri-state bus. The drive-enable is high only when bytes are actually presented. Reads return the stored byte. Programming can only clear bits: a pulse writes the AND of the stored byte and the presented byte. The identifier mode returns a manufacturer byte or a device byte, chosen by address bit 0. Bit 7 of each identifier byte is the odd-parity bit over bits 6:0.

All pins are plain level signals sampled on the clock. There is no stream handshake. Output pins are registered, so a change at the inputs shows at the outputs after one rising edge.

Top module: `uvprom_ctrl`

## Requirements
- R1: While `rst_n` is low, `dq_en` is 0 whatever the other inputs are.
- R2: With `ce_n`=0, `oe_n`=0 and `hv_a9`=0, one edge later `dq_en`=1 and `dq_o` equals the byte stored at `addr`.
- R3: With `ce_n`=1, one edge later `dq_en`=0, whatever `oe_n`, `hv_a9` or `vpp_on` are.
- R4: With `ce_n`=0 and `oe_n`=1, one edge later `dq_en`=0. This includes identifier requests.
- R5: A cycle with `erase_all`=1 sets every byte to 8'hFF.
- R6: A program pulse needs `vpp_on`=1, `oe_n`=1 and `ce_n`=0 for at least one edge. At the first edge where `ce_n` is back at 1 with `vpp_on` still 1, the byte at the pulse's address becomes the stored byte AND `din`, using the address and data of the pulse's last cycle. A 0 bit is never set back to 1.
- R7: With `vpp_on`=1 and `ce_n` held at 1, no byte changes, whatever `addr` and `din` do.
- R8: With `hv_a9`=1, `ce_n`=0, `oe_n`=0 and all address bits other than bits 0 and 9 at 0, `dq_o` returns the manufacturer byte when `addr[0]`=0 and the device byte when `addr[0]`=1. With the default parameters these are 8'h01 and 8'h9B.
- R9: Every identifier byte has an odd number of ones over its 8 bits. Bit 7 is the parity bit.
- R10: An identifier request with any address bit other than bits 0 and 9 at 1 returns 8'hFF.
- R11: With `vpp_on`=1, `ce_n`=0 and `oe_n`=0 (program verify), the stored byte is read out and no byte changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of the pin state (not of the cells) |
| ce_n | input | 1 | Chip select and program pulse, active low |
| oe_n | input | 1 | Output gate, active low |
| vpp_on | input | 1 | Programming supply present |
| hv_a9 | input | 1 | High voltage detected on address bit 9 |
| erase_all | input | 1 | Sets every cell byte to all ones |
| addr | input | AW | Byte address |
| din | input | 8 | Byte presented on the data pins for programming |
| dq_o | output | 8 | Byte driven onto the data pins |
| dq_en | output | 1 | Drive enable of the data pins (0 = high impedance) |

## Verification
The hardest condition to reach is a committed write that uses the address and data of the pulse's last cycle. The write lands on the rising edge of the chip select, when the pins show no mode that would write. Directed tests therefore hold a pulse across one edge and then raise `ce_n` with the supply still on. They read the byte back and then program it again with different data, to show that bits only clear. Inhibit is reached by moving `addr` and `din` while the supply is on and the chip is deselected, and a later read shows the byte unchanged. Malformed identifier requests come from a vector table that sets single stray address bits, and also sets bit 9 itself, which is allowed.

// File: rtl/uvprom_pkg.sv
package uvprom_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_INHIBIT,
    MD_OUTOFF,
    MD_READ,
    MD_PROGRAM,
    MD_IDENT
  } mode_e;

  // Bit 7 makes the total count of ones odd.
  function automatic logic [7:0] odd_parity_byte(input logic [6:0] low7);
    return {~(^low7), low7};
  endfunction

endpackage

// File: rtl/uvprom_mode_dec.sv
module uvprom_mode_dec
  import uvprom_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  vpp_on,
  input  logic  hv_a9,
  output mode_e mode
);

  always_comb begin
    if (ce_n) begin
      mode = vpp_on ? MD_INHIBIT : MD_STANDBY;
    end else if (!oe_n) begin
      mode = hv_a9 ? MD_IDENT : MD_READ;
    end else if (vpp_on) begin
      mode = MD_PROGRAM;
    end else begin
      mode = MD_OUTOFF;
    end
  end

endmodule

// File: rtl/uvprom_prog_seq.sv
module uvprom_prog_seq
  import uvprom_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mode_e         mode,
  input  logic          ce_n,
  input  logic          vpp_on,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);

  logic          pulse_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;

  // Track the pulse and keep the pins of its latest cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      pulse_q <= (mode == MD_PROGRAM);
      if (mode == MD_PROGRAM) begin
        addr_q <= addr;
        data_q <= din;
      end
    end
  end

  // Commit on the rising chip select, supply still present.
  assign wr_en   = pulse_q & ce_n & vpp_on;
  assign wr_addr = addr_q;
  assign wr_data = data_q;

endmodule

// File: rtl/uvprom_cells.sv
module uvprom_cells #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          erase_all,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  // Nonvolatile: no reset. Programming only clears bits.
  always_ff @(posedge clk) begin
    if (erase_all) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= 8'hFF;
      end
    end else if (wr_en) begin
      mem[wr_addr] <= mem[wr_addr] & wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/uvprom_ident.sv
module uvprom_ident
  import uvprom_pkg::*;
#(
  parameter int         AW      = 10,
  parameter int         ID_BIT  = 9,
  parameter logic [6:0] MFR_ID7 = 7'h01,
  parameter logic [6:0] DEV_ID7 = 7'h1B
) (
  input  logic [AW-1:0] addr,
  output logic [7:0]    id_byte
);

  localparam logic [AW-1:0] STRAY_MASK = ~(AW'(1) | (AW'(1) << ID_BIT));
  localparam logic [7:0]    MFR_BYTE   = odd_parity_byte(MFR_ID7);
  localparam logic [7:0]    DEV_BYTE   = odd_parity_byte(DEV_ID7);

  always_comb begin
    if (|(addr & STRAY_MASK)) begin
      id_byte = 8'hFF;
    end else if (addr[0]) begin
      id_byte = DEV_BYTE;
    end else begin
      id_byte = MFR_BYTE;
    end
  end

endmodule

// File: rtl/uvprom_dq_drv.sv
module uvprom_dq_drv
  import uvprom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mode_e      mode,
  input  logic [7:0] rd_data,
  input  logic [7:0] id_data,
  output logic [7:0] dq_o,
  output logic       dq_en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_en <= 1'b0;
      dq_o  <= '0;
    end else begin
      unique case (mode)
        MD_READ: begin
          dq_en <= 1'b1;
          dq_o  <= rd_data;
        end
        MD_IDENT: begin
          dq_en <= 1'b1;
          dq_o  <= id_data;
        end
        default: begin
          dq_en <= 1'b0;
          dq_o  <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/uvprom_ctrl.sv
module uvprom_ctrl
  import uvprom_pkg::*;
#(
  parameter int         AW      = 10,
  parameter int         ID_BIT  = 9,
  parameter logic [6:0] MFR_ID7 = 7'h01,
  parameter logic [6:0] DEV_ID7 = 7'h1B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          vpp_on,
  input  logic          hv_a9,
  input  logic          erase_all,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dq_o,
  output logic          dq_en
);

  mode_e         mode;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [7:0]    rd_data;
  logic [7:0]    id_data;

  uvprom_mode_dec u_dec (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .vpp_on (vpp_on),
    .hv_a9  (hv_a9),
    .mode   (mode)
  );

  uvprom_prog_seq #(.AW(AW)) u_prog (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .ce_n    (ce_n),
    .vpp_on  (vpp_on),
    .addr    (addr),
    .din     (din),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  uvprom_cells #(.AW(AW)) u_cells (
    .clk       (clk),
    .erase_all (erase_all),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (addr),
    .rd_data   (rd_data)
  );

  uvprom_ident #(
    .AW      (AW),
    .ID_BIT  (ID_BIT),
    .MFR_ID7 (MFR_ID7),
    .DEV_ID7 (DEV_ID7)
  ) u_ident (
    .addr    (addr),
    .id_byte (id_data)
  );

  uvprom_dq_drv u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .rd_data (rd_data),
    .id_data (id_data),
    .dq_o    (dq_o),
    .dq_en   (dq_en)
  );

endmodule

// File: rtl/uvprom_ctrl_chk.sv
module uvprom_ctrl_chk #(
  parameter int AW     = 10,
  parameter int ID_BIT = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          vpp_on,
  input logic          hv_a9,
  input logic [AW-1:0] addr,
  input logic [7:0]    dq_o,
  input logic          dq_en,
  input logic          wr_en
);

  logic [AW-1:0] stray_bits;
  logic          id_clean;

  always_comb begin
    stray_bits         = addr;
    stray_bits[0]      = 1'b0;
    stray_bits[ID_BIT] = 1'b0;
    id_clean           = (stray_bits == '0);
  end

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !hv_a9) |=> dq_en); // R2

  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dq_en); // R3

  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !dq_en); // R4

  AST_WRITE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (vpp_on && ce_n)); // R6

  AST_INHIBIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && $past(ce_n)) |-> !wr_en); // R7

  AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && hv_a9 && id_clean) |=> ($countones(dq_o) % 2 == 1)); // R9

  AST_ID_STRAY_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && hv_a9 && !id_clean) |=> (dq_o == 8'hFF)); // R10

endmodule

bind uvprom_ctrl uvprom_ctrl_chk #(.AW(AW), .ID_BIT(ID_BIT)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ce_n   (ce_n),
  .oe_n   (oe_n),
  .vpp_on (vpp_on),
  .hv_a9  (hv_a9),
  .addr   (addr),
  .dq_o   (dq_o),
  .dq_en  (dq_en),
  .wr_en  (wr_en)
);

// File: tb/uvprom_ctrl_tb_top.sv
`timescale 1ns/100ps
module uvprom_ctrl_tb_top;

  localparam int AW = 10;
  localparam int NV = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          vpp_on = 1'b0;
  logic          hv_a9 = 1'b0;
  logic          erase_all = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dq_o;
  logic          dq_en;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  uvprom_ctrl #(.AW(AW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .vpp_on    (vpp_on),
    .hv_a9     (hv_a9),
    .erase_all (erase_all),
    .addr      (addr),
    .din       (din),
    .dq_o      (dq_o),
    .dq_en     (dq_en)
  );

  // {ce_n, oe_n, vpp_on, hv_a9, addr[9:0], exp_en, exp_data[7:0]}
  localparam logic [22:0] VEC [NV] = '{
    {4'b0000, 10'h005, 1'b1, 8'hFF},
    {4'b1000, 10'h005, 1'b0, 8'h00},
    {4'b1100, 10'h005, 1'b0, 8'h00},
    {4'b0100, 10'h005, 1'b0, 8'h00},
    {4'b0001, 10'h000, 1'b1, 8'h01},
    {4'b0001, 10'h001, 1'b1, 8'h9B},
    {4'b0001, 10'h200, 1'b1, 8'h01},
    {4'b0001, 10'h201, 1'b1, 8'h9B},
    {4'b0001, 10'h004, 1'b1, 8'hFF},
    {4'b0001, 10'h081, 1'b1, 8'hFF},
    {4'b0101, 10'h000, 1'b0, 8'h00},
    {4'b1001, 10'h000, 1'b0, 8'h00},
    {4'b0010, 10'h007, 1'b1, 8'hFF}
  };
  localparam string TAGS [NV] = '{
    "R2", "R3", "R3", "R4", "R8", "R8", "R8", "R8",
    "R10", "R10", "R4", "R3", "R11"
  };

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_dq(input string tag, input logic exp_en, input logic [7:0] exp_d);
    n_checks++;
    if (dq_en !== exp_en || (exp_en && dq_o !== exp_d)) begin
      n_fails++;
      $display("FAIL %s: dq_en=%0b dq_o=%02h expected dq_en=%0b dq_o=%02h",
               tag, dq_en, dq_o, exp_en, exp_d);
    end
  endtask

  task automatic set_pins(input logic c, input logic o, input logic v, input logic h,
                          input logic [AW-1:0] a);
    ce_n = c; oe_n = o; vpp_on = v; hv_a9 = h; addr = a;
  endtask

  task automatic read_byte(input string tag, input logic [AW-1:0] a, input logic [7:0] exp_d);
    set_pins(1'b0, 1'b0, 1'b0, 1'b0, a);
    cyc();
    check_dq(tag, 1'b1, exp_d);
  endtask

  task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d);
    set_pins(1'b0, 1'b1, 1'b1, 1'b0, a);
    din = d;
    cyc();
    ce_n = 1'b1;
    cyc();
    vpp_on = 1'b0;
    din = 8'h00;
    cyc();
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    // R1: outputs stay off during reset even with a read requested
    set_pins(1'b0, 1'b0, 1'b0, 1'b0, 10'h000);
    cyc();
    cyc();
    check_dq("R1", 1'b0, 8'h00);
    rst_n = 1'b1;
    set_pins(1'b1, 1'b1, 1'b0, 1'b0, 10'h000);
    cyc();

    // R5: erase the whole array
    erase_all = 1'b1;
    cyc();
    erase_all = 1'b0;
    read_byte("R5", 10'h3FF, 8'hFF);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      set_pins(v[22], v[21], v[20], v[19], v[18:9]);
      cyc();
      check_dq(TAGS[i], v[8], v[7:0]);
    end

    // R9: identifier bytes carry odd parity
    set_pins(1'b0, 1'b0, 1'b0, 1'b1, 10'h000);
    cyc();
    n_checks++;
    if ($countones(dq_o) % 2 != 1) begin
      n_fails++;
      $display("FAIL R9: manufacturer byte %02h, expected odd ones count", dq_o);
    end
    addr = 10'h001;
    cyc();
    n_checks++;
    if ($countones(dq_o) % 2 != 1) begin
      n_fails++;
      $display("FAIL R9: device byte %02h, expected odd ones count", dq_o);
    end

    // R6: program, then program again: bits only clear
    program_byte(10'h005, 8'hA5);
    read_byte("R6", 10'h005, 8'hA5);
    program_byte(10'h005, 8'h5F);
    read_byte("R6", 10'h005, 8'h05);
    program_byte(10'h005, 8'hFF);
    read_byte("R6", 10'h005, 8'h05);
    read_byte("R6", 10'h006, 8'hFF);

    // R6: last cycle of the pulse picks address and data
    set_pins(1'b0, 1'b1, 1'b1, 1'b0, 10'h010);
    din = 8'h00;
    cyc();
    addr = 10'h011;
    din = 8'hF0;
    cyc();
    ce_n = 1'b1;
    cyc();
    vpp_on = 1'b0;
    cyc();
    read_byte("R6", 10'h011, 8'hF0);
    read_byte("R6", 10'h010, 8'hFF);

    // R7: supply on, chip deselected, pins moving
    set_pins(1'b1, 1'b1, 1'b1, 1'b0, 10'h005);
    for (int k = 0; k < 4; k++) begin
      addr = (k % 2 == 0) ? 10'h005 : 10'h020;
      din = 8'h00;
      cyc();
      check_dq("R7", 1'b0, 8'h00);
    end
    vpp_on = 1'b0;
    cyc();
    read_byte("R7", 10'h005, 8'h05);
    read_byte("R7", 10'h020, 8'hFF);

    // R11: verify read with supply on, then nothing changed
    set_pins(1'b0, 1'b0, 1'b1, 1'b0, 10'h005);
    din = 8'h00;
    cyc();
    check_dq("R11", 1'b1, 8'h05);
    ce_n = 1'b1;
    cyc();
    vpp_on = 1'b0;
    read_byte("R11", 10'h005, 8'h05);

    // R5: erase restores all ones
    set_pins(1'b1, 1'b1, 1'b0, 1'b0, 10'h000);
    erase_all = 1'b1;
    cyc();
    erase_all = 1'b0;
    read_byte("R5", 10'h005, 8'hFF);
    read_byte("R5", 10'h011, 8'hFF);

    // R1: reset in mid-read turns the drive off
    rst_n = 1'b0;
    #1;
    check_dq("R1", 1'b0, 8'h00);
    cyc();
    rst_n = 1'b1;

    finish_run();
  end

endmodule